// File: doc/BRIEF.md
# Flash-to-Parallel Configuration Stream Loader

This block brings up an FPGA from images held in a 16-bit parallel NOR flash. On a start pulse it resets the target by pulsing its active-low configuration request, waits for the target's active-low status line to return high, and then reads a two-word header from the chosen image slot. The header gives a pacing mode and a payload length. The block then fetches the payload word by word and sends it to the target over an 8-bit data bus with a clock it drives itself, low byte first. After the last payload byte it keeps clocking until the target raises its configuration-done line.

There are two slots: a user slot at flash word address 0x000000 and a factory slot at 0x200000. A settings area at 0x3F0000 belongs to neither slot and is never read. If the user image fails, the block restarts the target from the factory slot. An image fails when the target pulls its status line low, when the header carries an unknown mode, or when the done line stays low for too long. If the factory image also fails, the block stops and raises a sticky error.

Flash access time is covered by a parameterised wait. Each read holds the address for a fixed number of cycles before the data word is captured.

Top module: `cfg_stream_loader`

## Requirements
- R1: After reset `cfg_nconfig` is 1, `cfg_dclk` is 0, `done` and `err` are 0 and `flash_oe_n` is 1. Nothing changes until `start` is pulsed.
- R2: `start` in idle drives `cfg_nconfig` low for NCFG_CYC cycles (at least 2). The block reads no flash until `cfg_nstatus` is high again. The first read of an attempt is at the slot base address.
- R3: The word at slot base is the mode word. Bits [1:0] = 00 selects normal pacing and 01 selects compressed pacing; bits [15:2] are ignored. Any other value of bits [1:0] is an invalid header, and the attempt fails with no DCLK pulse. The word at base+1 is the payload length in flash words. Header words are never sent; the payload starts at base+2.
- R4: Each payload word is sent as its bits [7:0] first, then its bits [15:8].
- R5: In normal pacing each byte gets exactly one DCLK pulse, so 2 pulses per flash word.
- R6: In compressed pacing each byte is held for exactly 4 DCLK pulses, so 8 pulses per flash word.
- R7: `cfg_data` changes only while `cfg_dclk` is low. It already holds its value in the cycle before each DCLK rising edge. DCLK is never high for two cycles in a row.
- R8: During a read, `flash_oe_n` stays low and `flash_addr` stays stable for exactly ACC_WAIT+1 cycles. No address at or above 0x3F0000 is ever read.
- R9: After the payload, extra DCLK pulses are sent until `cfg_conf_done` is seen high, at most 64 of them. When `cfg_conf_done` is seen, `done` rises. If it is still low after 64 extra pulses, the attempt fails.
- R10: A failure of the user attempt (status low during header, payload or tail; invalid mode; tail timeout) stops clocking at once. The block then restarts the target with a new `cfg_nconfig` pulse and loads the factory slot.
- R11: A failure of the factory attempt sets `err`. There is no further attempt, and `start` is ignored until reset.
- R12: `done` and `err` are never high together, and each stays high until reset.
- R13: A payload length of 0 sends no payload pulses and goes straight to the tail pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse in idle to begin a load |
| flash_addr | output | ADDR_W | Flash word address |
| flash_oe_n | output | 1 | Active-low flash read enable |
| flash_dq | input | 16 | Flash read data |
| cfg_nconfig | output | 1 | Active-low configuration request to target |
| cfg_dclk | output | 1 | Configuration data clock |
| cfg_data | output | 8 | Configuration data byte |
| cfg_nstatus | input | 1 | Active-low target status / error |
| cfg_conf_done | input | 1 | Target configuration complete |
| done | output | 1 | Target configured |
| err | output | 1 | Both slots failed (sticky) |

## Verification
The assertions take for granted that once the target pulls its status line low, it keeps it low until the next configuration request. They also assume the done line rises only after every payload pulse has arrived, and that the flash word is stable for the whole read window. The bench's target model raises its status line a few cycles after the request is released. It injects status errors only at a pulse number inside the payload, and raises the done line only after the payload plus the chosen tail count, so the stimulus stays within these assumptions. The flash model returns a word that depends only on the address, and it updates away from the sampling edge.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    localparam logic [1:0] MODE_NORMAL = 2'b00;
    localparam logic [1:0] MODE_COMP   = 2'b01;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_NCFG,
        ST_WST,
        ST_H0_REQ,
        ST_H0_WAIT,
        ST_H1_REQ,
        ST_H1_WAIT,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_SEND,
        ST_SWAIT,
        ST_TAIL,
        ST_DONE,
        ST_FAIL
    } seq_state_t;

    typedef enum logic {
        SLOT_USER,
        SLOT_FACT
    } slot_t;

    typedef struct packed {
        logic ok;
        logic comp;
    } pace_t;

    typedef struct packed {
        logic        load;
        logic        tail;
        logic        comp;
        logic [15:0] word;
    } pace_cmd_t;

    function automatic pace_t decode_pace(input logic [15:0] w);
        pace_t p;
        p.ok   = (w[1:0] == MODE_NORMAL) || (w[1:0] == MODE_COMP);
        p.comp = (w[1:0] == MODE_COMP);
        return p;
    endfunction

endpackage

// File: rtl/cfgld_flash_rd.sv
module cfgld_flash_rd #(
    parameter int ADDR_W   = 24,
    parameter int ACC_WAIT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [ADDR_W-1:0] flash_addr,
    output logic              flash_oe_n,
    input  logic [15:0]       flash_dq,
    output logic              rd_valid,
    output logic [15:0]       rd_data
);
    localparam int CW = (ACC_WAIT < 1) ? 1 : $clog2(ACC_WAIT + 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            flash_addr <= '0;
            flash_oe_n <= 1'b1;
            busy_q     <= 1'b0;
            cnt_q      <= '0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (!busy_q && req) begin
                flash_addr <= req_addr;
                flash_oe_n <= 1'b0;
                busy_q     <= 1'b1;
                cnt_q      <= CW'(ACC_WAIT);
            end else if (busy_q) begin
                if (cnt_q != '0) begin
                    cnt_q <= cnt_q - 1'b1;
                end else begin
                    rd_data    <= flash_dq;
                    rd_valid   <= 1'b1;
                    flash_oe_n <= 1'b1;
                    busy_q     <= 1'b0;
                end
            end
        end
    end

    // R8: the address does not move inside a read window
    a_r8_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (!flash_oe_n && $past(!flash_oe_n)) |-> $stable(flash_addr));

endmodule

// File: rtl/cfgld_pacer.sv
module cfgld_pacer
    import cfgld_pkg::*;
#(
    parameter int COMP_PULSES = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      abort,
    input  pace_cmd_t cmd,
    output logic      busy,
    output logic      dclk,
    output logic [7:0] data
);
    localparam int RW = $clog2(COMP_PULSES + 1);

    logic [7:0]    hi_q;
    logic          more_q;
    logic [RW-1:0] per_q;
    logic [RW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy   <= 1'b0;
            dclk   <= 1'b0;
            data   <= '0;
            hi_q   <= '0;
            more_q <= 1'b0;
            per_q  <= '0;
            left_q <= '0;
        end else if (!busy && cmd.load) begin
            busy   <= 1'b1;
            dclk   <= 1'b0;
            data   <= cmd.tail ? 8'h00 : cmd.word[7:0];
            hi_q   <= cmd.word[15:8];
            more_q <= !cmd.tail;
            per_q  <= (cmd.comp && !cmd.tail) ? RW'(COMP_PULSES) : RW'(1);
            left_q <= (cmd.comp && !cmd.tail) ? RW'(COMP_PULSES) : RW'(1);
        end else if (busy) begin
            if (!dclk) begin
                dclk <= 1'b1;
            end else begin
                dclk <= 1'b0;
                if (left_q > RW'(1)) begin
                    left_q <= left_q - 1'b1;
                end else if (more_q) begin
                    data   <= hi_q;
                    more_q <= 1'b0;
                    left_q <= per_q;
                end else begin
                    busy <= 1'b0;
                end
            end
        end
    end

    // R7: byte already present in the cycle before each rising edge
    a_r7_setup: assert property (@(posedge clk) disable iff (rst)
        $rose(dclk) |-> $stable(data));
    // R7: the byte only moves while the clock is low
    a_r7_change_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(data) |-> !dclk);
    // R7: single-cycle high phase
    a_r7_short_high: assert property (@(posedge clk) disable iff (rst)
        dclk |=> !dclk);

endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
    import cfgld_pkg::*;
#(
    parameter int              ADDR_W      = 24,
    parameter logic [ADDR_W-1:0] USER_BASE = 24'h000000,
    parameter logic [ADDR_W-1:0] FACT_BASE = 24'h200000,
    parameter logic [ADDR_W-1:0] OPT_BASE  = 24'h3F0000,
    parameter int              ACC_WAIT    = 2,
    parameter int              NCFG_CYC    = 4,
    parameter int              TAIL_MAX    = 64,
    parameter int              COMP_PULSES = 4,
    parameter int              LEN_W       = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic [ADDR_W-1:0] flash_addr,
    output logic              flash_oe_n,
    input  logic [15:0]       flash_dq,
    output logic              cfg_nconfig,
    output logic              cfg_dclk,
    output logic [7:0]        cfg_data,
    input  logic              cfg_nstatus,
    input  logic              cfg_conf_done,
    output logic              done,
    output logic              err
);
    localparam int NCFG_N = (NCFG_CYC < 2) ? 2 : NCFG_CYC;
    localparam int NW     = $clog2(NCFG_N);
    localparam int TW     = $clog2(TAIL_MAX + 1);

    seq_state_t        state_q;
    slot_t             slot_q;
    logic              comp_q;
    logic [LEN_W-1:0]  left_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [NW-1:0]     ncnt_q;
    logic [TW-1:0]     tail_q;
    logic [15:0]       word_q;

    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_valid;
    logic [15:0]       rd_data;
    pace_cmd_t         pcmd;
    logic              p_busy;
    logic              streaming;
    logic              fault;
    pace_t             hdr;
    logic [ADDR_W-1:0] base;

    assign base = (slot_q == SLOT_FACT) ? FACT_BASE : USER_BASE;

    always_comb begin
        hdr       = decode_pace(rd_data);
        streaming = state_q inside {ST_H0_REQ, ST_H0_WAIT, ST_H1_REQ, ST_H1_WAIT,
                                    ST_RD_REQ, ST_RD_WAIT, ST_SEND, ST_SWAIT, ST_TAIL};
        fault     = (streaming && !cfg_nstatus)
                 || (state_q == ST_H0_WAIT && rd_valid && !hdr.ok)
                 || (state_q == ST_TAIL && !p_busy && !cfg_conf_done
                     && tail_q == TW'(TAIL_MAX));
        rd_req  = 1'b0;
        rd_addr = ptr_q;
        pcmd    = '0;
        case (state_q)
            ST_H0_REQ: begin rd_req = 1'b1; rd_addr = base; end
            ST_H1_REQ: begin rd_req = 1'b1; rd_addr = base + ADDR_W'(1); end
            ST_RD_REQ: rd_req = 1'b1;
            ST_SEND: begin
                pcmd.load = 1'b1;
                pcmd.comp = comp_q;
                pcmd.word = word_q;
            end
            ST_TAIL: begin
                if (!p_busy && !cfg_conf_done && tail_q != TW'(TAIL_MAX)) begin
                    pcmd.load = 1'b1;
                    pcmd.tail = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            slot_q  <= SLOT_USER;
            comp_q  <= 1'b0;
            left_q  <= '0;
            ptr_q   <= '0;
            ncnt_q  <= '0;
            tail_q  <= '0;
            word_q  <= '0;
        end else if (fault) begin
            if (slot_q == SLOT_USER) begin
                slot_q  <= SLOT_FACT;
                state_q <= ST_NCFG;
                ncnt_q  <= '0;
            end else begin
                state_q <= ST_FAIL;
            end
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    slot_q  <= SLOT_USER;
                    state_q <= ST_NCFG;
                    ncnt_q  <= '0;
                end
                ST_NCFG: begin
                    ncnt_q <= ncnt_q + 1'b1;
                    if (ncnt_q == NW'(NCFG_N - 1)) state_q <= ST_WST;
                end
                ST_WST:    if (cfg_nstatus) state_q <= ST_H0_REQ;
                ST_H0_REQ: state_q <= ST_H0_WAIT;
                ST_H0_WAIT: if (rd_valid) begin
                    comp_q  <= hdr.comp;
                    state_q <= ST_H1_REQ;
                end
                ST_H1_REQ: state_q <= ST_H1_WAIT;
                ST_H1_WAIT: if (rd_valid) begin
                    left_q <= LEN_W'(rd_data);
                    ptr_q  <= base + ADDR_W'(2);
                    tail_q <= '0;
                    state_q <= (rd_data == '0) ? ST_TAIL : ST_RD_REQ;
                end
                ST_RD_REQ: state_q <= ST_RD_WAIT;
                ST_RD_WAIT: if (rd_valid) begin
                    word_q  <= rd_data;
                    ptr_q   <= ptr_q + ADDR_W'(1);
                    left_q  <= left_q - 1'b1;
                    state_q <= ST_SEND;
                end
                ST_SEND: state_q <= ST_SWAIT;
                ST_SWAIT: if (!p_busy) begin
                    tail_q  <= '0;
                    state_q <= (left_q == '0) ? ST_TAIL : ST_RD_REQ;
                end
                ST_TAIL: if (!p_busy) begin
                    if (cfg_conf_done) state_q <= ST_DONE;
                    else               tail_q  <= tail_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign cfg_nconfig = (state_q != ST_NCFG);
    assign done        = (state_q == ST_DONE);
    assign err         = (state_q == ST_FAIL);

    cfgld_flash_rd #(
        .ADDR_W   (ADDR_W),
        .ACC_WAIT (ACC_WAIT)
    ) u_rd (
        .clk        (clk),
        .rst        (rst),
        .abort      (fault),
        .req        (rd_req),
        .req_addr   (rd_addr),
        .flash_addr (flash_addr),
        .flash_oe_n (flash_oe_n),
        .flash_dq   (flash_dq),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    cfgld_pacer #(
        .COMP_PULSES (COMP_PULSES)
    ) u_pace (
        .clk   (clk),
        .rst   (rst),
        .abort (fault),
        .cmd   (pcmd),
        .busy  (p_busy),
        .dclk  (cfg_dclk),
        .data  (cfg_data)
    );

    // R8: settings area never addressed
    a_r8_no_option_area: assert property (@(posedge clk) disable iff (rst)
        !flash_oe_n |-> (flash_addr < OPT_BASE));
    // R2: request low for at least two cycles
    a_r2_ncfg_width: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_nconfig) |-> !$past(cfg_nconfig, 2));
    // R10: no clocking while the target is held in reset
    a_r10_quiet_ncfg: assert property (@(posedge clk) disable iff (rst)
        !cfg_nconfig |-> !cfg_dclk);
    // R11: error stays once raised
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err |=> err);
    // R12: done stays and never coexists with err
    a_r12_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done |=> (done && !err));
    a_r12_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

endmodule

// File: tb/cfg_stream_loader_bench.sv
module cfg_stream_loader_bench;
    localparam int              ADDR_W   = 24;
    localparam logic [23:0]     USER_B   = 24'h000000;
    localparam logic [23:0]     FACT_B   = 24'h200000;
    localparam logic [23:0]     OPT_B    = 24'h3F0000;
    localparam int              ACC_WAIT = 2;
    localparam int              TAILMAX  = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] flash_addr;
    logic              flash_oe_n;
    logic [15:0]       flash_dq = '0;
    logic              cfg_nconfig, cfg_dclk, done, err;
    logic [7:0]        cfg_data;
    logic              nst = 1'b1;
    logic              cdone = 1'b0;

    always #4 clk = ~clk;

    cfg_stream_loader u_cfg_stream_loader (
        .clk(clk), .rst(rst), .start(start),
        .flash_addr(flash_addr), .flash_oe_n(flash_oe_n), .flash_dq(flash_dq),
        .cfg_nconfig(cfg_nconfig), .cfg_dclk(cfg_dclk), .cfg_data(cfg_data),
        .cfg_nstatus(nst), .cfg_conf_done(cdone),
        .done(done), .err(err)
    );

    // scenario
    logic [15:0] hmode [2];
    int          hlen  [2];
    int          xtra  [2];
    int          eat   [2];

    int nchecks = 0;
    int nfail   = 0;

    // observations
    int att, pulses[2], mism[2], first_addr[2];
    int setup_viol, dbl_high, bad_run, addr_unst, opt_hits, early_rd, ncfg_min;
    int dl, run, ncfg_run;
    bit failed, first_pend, prev_dclk, prev_ncfg;
    logic [7:0]  prev_data;
    logic [23:0] last_addr;

    function automatic logic [23:0] sbase(input int i);
        return (i == 0) ? USER_B : FACT_B;
    endfunction

    function automatic logic [15:0] fmodel(input logic [23:0] a);
        logic [31:0] h;
        if (a == USER_B)       return hmode[0];
        if (a == USER_B + 1)   return 16'(hlen[0]);
        if (a == FACT_B)       return hmode[1];
        if (a == FACT_B + 1)   return 16'(hlen[1]);
        h = {8'h0, a} * 32'h9E3779B1;
        return h[22:7] ^ a[15:0];
    endfunction

    function automatic int rep(input int i);
        return (hmode[i][1:0] == 2'b01) ? 4 : 1;
    endfunction

    function automatic int payload(input int i);
        return hlen[i] * 2 * rep(i);
    endfunction

    function automatic bit mode_ok(input int i);
        return hmode[i][1:0] == 2'b00 || hmode[i][1:0] == 2'b01;
    endfunction

    function automatic bit att_ok(input int i);
        return mode_ok(i) && xtra[i] <= TAILMAX && eat[i] == 0;
    endfunction

    function automatic logic [7:0] exp_byte(input int i, input int p);
        int b;
        logic [15:0] w;
        b = p / rep(i);
        w = fmodel(sbase(i) + 24'(2 + b / 2));
        return (b % 2 == 1) ? w[15:8] : w[7:0];
    endfunction

    // target and flash models, updated away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            att = 0; nst = 1'b1; cdone = 1'b0; failed = 0; dl = 0; run = 0;
            ncfg_run = 0; ncfg_min = 1000; first_pend = 0;
            prev_dclk = 0; prev_ncfg = 1; prev_data = '0; last_addr = '0;
            setup_viol = 0; dbl_high = 0; bad_run = 0; addr_unst = 0;
            opt_hits = 0; early_rd = 0;
            for (int i = 0; i < 2; i++) begin
                pulses[i] = 0; mism[i] = 0; first_addr[i] = -1;
            end
        end else begin
            flash_dq <= fmodel(flash_addr);
            if (!cfg_nconfig) begin
                if (prev_ncfg) begin att++; first_pend = 1; end
                nst = 1'b0; cdone = 1'b0; failed = 0; dl = 3; ncfg_run++;
            end else begin
                if (!prev_ncfg) begin
                    if (ncfg_run < ncfg_min) ncfg_min = ncfg_run;
                    ncfg_run = 0;
                end else if (!failed && !nst) begin
                    if (dl == 0) nst = 1'b1; else dl--;
                end
            end
            if (cfg_dclk && prev_dclk) dbl_high++;
            if (cfg_dclk && !prev_dclk && att >= 1 && att <= 2) begin
                int ix, p;
                ix = att - 1;
                p  = pulses[ix];
                if (cfg_data != prev_data) setup_viol++;
                if (p < payload(ix) && cfg_data != exp_byte(ix, p)) mism[ix]++;
                pulses[ix] = p + 1;
                if (eat[ix] == p + 1) begin nst = 1'b0; failed = 1; end
                if (p + 1 == payload(ix) + xtra[ix]) cdone = 1'b1;
            end
            if (!flash_oe_n) begin
                if (run > 0 && flash_addr != last_addr) addr_unst++;
                if (flash_addr >= OPT_B) opt_hits++;
                if (!nst && !failed) early_rd++;
                if (run == 0 && first_pend && att >= 1 && att <= 2) begin
                    first_addr[att-1] = int'(flash_addr);
                    first_pend = 0;
                end
                run++;
                last_addr = flash_addr;
            end else if (run > 0) begin
                if (run != ACC_WAIT + 1) bad_run++;
                run = 0;
            end
            prev_dclk = cfg_dclk;
            prev_ncfg = cfg_nconfig;
            prev_data = cfg_data;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        nchecks++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_case(input string tag,
                            input logic [15:0] m0, input int l0, input int x0, input int e0,
                            input logic [15:0] m1, input int l1, input int x1, input int e1);
        bit ok0, ok1, exp_done;
        int f, k;
        hmode[0] = m0; hlen[0] = l0; xtra[0] = x0; eat[0] = e0;
        hmode[1] = m1; hlen[1] = l1; xtra[1] = x1; eat[1] = e1;
        do_reset();
        pulse_start();
        k = 0;
        while (!(done || err) && k < 40000) begin @(negedge clk); k++; end
        repeat (20) @(negedge clk);
        ok0 = att_ok(0);
        ok1 = att_ok(1);
        exp_done = ok0 || ok1;
        chk("R10", {tag, " done"}, done, exp_done);
        chk("R11", {tag, " err"}, err, !exp_done);
        chk("R12", {tag, " done&err"}, done && err, 0);
        chk("R10", {tag, " attempts"}, att, ok0 ? 1 : 2);
        if (!ok0) begin
            if (!mode_ok(0))      chk("R3",  {tag, " pulses on bad header"}, pulses[0], 0);
            else if (eat[0] != 0) chk("R10", {tag, " pulses before abort"}, pulses[0], eat[0]);
            else                  chk("R9",  {tag, " timeout pulses"}, pulses[0], payload(0) + TAILMAX);
            chk("R4", {tag, " user bytes before failure"}, mism[0], 0);
        end
        if (exp_done) begin
            f = ok0 ? 0 : 1;
            chk("R4", {tag, " byte mismatches"}, mism[f], 0);
            if (hlen[f] == 0)
                chk("R13", {tag, " tail-only pulses"}, pulses[f], xtra[f]);
            else if (rep(f) == 4)
                chk("R6", {tag, " compressed pulses"}, pulses[f], payload(f) + xtra[f]);
            else
                chk("R5", {tag, " normal pulses"}, pulses[f], payload(f) + xtra[f]);
        end
        if (!ok0) chk("R10", {tag, " factory first read"}, first_addr[1], int'(FACT_B));
        chk("R2", {tag, " user first read"}, first_addr[0], int'(USER_B));
        chk("R2", {tag, " read before status high"}, early_rd, 0);
        chk("R2", {tag, " request width >= 2"}, ncfg_min >= 2, 1);
        chk("R7", {tag, " setup violations"}, setup_viol + dbl_high, 0);
        chk("R8", {tag, " read window"}, bad_run + addr_unst, 0);
        chk("R8", {tag, " settings area reads"}, opt_hits, 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        nchecks++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
        $finish;
    end

    initial begin : main
        int seed;
        seed = $urandom(32'd20240611);
        hmode[0] = 16'h0; hmode[1] = 16'h0;
        hlen[0] = 1; hlen[1] = 1; xtra[0] = 0; xtra[1] = 0; eat[0] = 0; eat[1] = 0;
        do_reset();
        // R1 reset state and idle without start
        chk("R1", "nconfig", cfg_nconfig, 1);
        chk("R1", "dclk", cfg_dclk, 0);
        chk("R1", "done", done, 0);
        chk("R1", "err", err, 0);
        chk("R1", "oe_n", flash_oe_n, 1);
        repeat (30) @(negedge clk);
        chk("R1", "no attempt without start", att, 0);

        run_case("normal",      16'h0000, 5, 3, 0,  16'h0000, 2, 0, 0);
        run_case("compressed",  16'hABC1, 3, 0, 0,  16'h0000, 2, 0, 0);
        run_case("status-err",  16'h0000, 6, 2, 4,  16'h0000, 4, 2, 0);
        run_case("bad-mode",    16'h0002, 3, 1, 0,  16'h0001, 2, 5, 0);
        run_case("both-fail",   16'h0000, 3, 1, 1,  16'h0001, 2, 1, 3);
        // R11: no further attempt even on a new start
        pulse_start();
        repeat (200) @(negedge clk);
        chk("R11", "attempts after start in error", att, 2);
        chk("R11", "err held", err, 1);
        chk("R11", "nconfig held high", cfg_nconfig, 1);
        run_case("tail-64",     16'h0000, 2, 64, 0, 16'h0000, 2, 0, 0);
        run_case("tail-65",     16'h0000, 2, 65, 0, 16'h0000, 1, 0, 0);
        run_case("zero-len",    16'h0000, 0, 7, 0,  16'h0000, 1, 0, 0);

        for (int n = 0; n < 8; n++) begin
            logic [15:0] m[2];
            int l[2], x[2], e[2];
            for (int i = 0; i < 2; i++) begin
                m[i] = {14'($urandom), (($urandom % 6) == 0) ? 2'b11 : 2'($urandom % 2)};
                l[i] = 1 + $urandom % 12;
                x[i] = $urandom % 70;
                e[i] = (($urandom % 4) == 0) ? 1 + int'($urandom % (l[i] * 2)) : 0;
            end
            run_case($sformatf("rand%0d", n), m[0], l[0], x[0], e[0], m[1], l[1], x[1], e[1]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
        $finish;
    end

endmodule